// File: doc/BRIEF.md
# Media Subsystem Control Register Bank

This block is a bank of 32-bit control registers reached over a simple single-cycle bus with a select strobe, a write flag, a byte address, write data, read data, a ready pulse and an error flag. The registers steer five media subsystems: a camera sensor interface, a display controller, a pixel processor, a camera serial receiver and a display serial transmitter. Each subsystem receives a soft-reset release and a clock-gate request, and seven bus masters receive a pair of four-bit priorities (a configured level and a fallback level) that the interconnect consumes.

The bank decodes a 4 KiB window but permits only six word-aligned offsets. Anything else in the window (unused words, misaligned addresses, words beyond the last register) is refused with an error, returns zero data and leaves all state untouched. Every access, accepted or refused, is answered by a ready pulse exactly one cycle after the select strobe.

After reset every subsystem is held in reset with its clock gated. Software releases a subsystem by setting all of the reset bits assigned to it, and lets its clock run by clearing all of its gate bits.

Top module: `media_ctl_regs`

## Requirements
- R1: After reset, offset 0x0 reads 0x00000000, offset 0x4 reads 0xFFFFFFFF, offsets 0xC, 0x10, 0x14 and 0x1C read zero, `sub_rst_n` is 5'b00000, `sub_clk_gate` is 5'b11111 and all priority outputs are zero.
- R2: The accepted offsets are exactly 0x0, 0x4, 0xC, 0x10, 0x14 and 0x1C; a write there stores all 32 bits and a later read returns them with `bus_err` low. A read never changes state.
- R3: An access to any other address of the window, including 0x8, 0x18, 0x20 to 0xFFC and any address with bits 1:0 not zero, sets `bus_err`, returns `bus_rdata` of zero and changes no register or output.
- R4: `bus_ready` is high for exactly the one cycle after each cycle with `bus_sel` high and low otherwise; `bus_err` is only high together with `bus_ready`; writes return zero read data.
- R5: Subsystem index k is released (`sub_rst_n[k]`=1) only when every bit of its group at offset 0x0 is 1: index 0 bits 3:2, index 1 bits 6:4, index 2 bits 8:7, index 3 bits 10:9, index 4 bits 12:11.
- R6: `sub_clk_gate[k]` is 1 when any bit of the same group at offset 0x4 is 1, and 0 only when all of them are 0.
- R7: Priority channel 0 (display) takes its configured level from bits 11:8 and its fallback level from bits 15:12 of offset 0xC.
- R8: Channel 1 (pixel read) uses bits 27:24 configured and 31:28 fallback of offset 0x10; channel 2 (pixel write) uses bits 19:16 configured and 23:20 fallback.
- R9: Channels 3 to 6 (sensor Y-write, Y-read, U, V) use consecutive bytes of offset 0x1C from bit 0 upward, configured level in the low nibble and fallback in the high nibble of each byte.
- R10: Offset 0x14 is a plain read/write word that drives no output.
- R11: Channel k of `prio_cfg`/`prio_dflt` occupies bits 4k+3:4k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address inside the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with `bus_ready` |
| bus_ready | output | 1 | Access completion pulse |
| bus_err | output | 1 | Access refused |
| sub_rst_n | output | 5 | Per-subsystem reset release, active low reset |
| sub_clk_gate | output | 5 | Per-subsystem clock gate request |
| prio_cfg | output | 28 | Configured priority, 4 bits per channel |
| prio_dflt | output | 28 | Fallback priority, 4 bits per channel |

## Verification
The assertions assume that `bus_sel` is a one-cycle strobe whose address, write flag and data are stable in that cycle and that `rst` is asserted from the first clock. They also assume nothing but the bus changes the registers, so a refused or read access must leave the storage stable in the following cycle. The stimulus meets this by driving each access for exactly one cycle from the falling edge, leaving an idle cycle after it, and holding reset for several cycles at the start.

// File: rtl/media_ctl_pkg.sv
package media_ctl_pkg;

    localparam int DW      = 32;
    localparam int AW      = 12;
    localparam int NSLOT   = 6;
    localparam int SLOT_W  = $clog2(NSLOT);
    localparam int NSUB    = 5;
    localparam int NCH     = 7;
    localparam int PW      = 4;
    localparam int WIDX_W  = AW - 2;

    localparam int SLOT_RST   = 0;
    localparam int SLOT_GATE  = 1;
    localparam int SLOT_DISP  = 2;
    localparam int SLOT_PIX   = 3;
    localparam int SLOT_CACHE = 4;
    localparam int SLOT_CAM   = 5;

    typedef struct packed {
        logic              sel;
        logic              wr;
        logic [AW-1:0]     addr;
        logic [DW-1:0]     wdata;
    } bus_req_t;

    typedef struct packed {
        logic              hit;
        logic [SLOT_W-1:0] slot;
    } decode_t;

    typedef struct packed {
        logic              ready;
        logic              err;
        logic [DW-1:0]     rdata;
    } bus_rsp_t;

    // Word index to storage slot; only six words are populated.
    function automatic decode_t word_decode(input logic [WIDX_W-1:0] widx);
        decode_t d;
        d.hit  = 1'b1;
        d.slot = '0;
        case (widx)
            WIDX_W'(0): d.slot = SLOT_W'(SLOT_RST);
            WIDX_W'(1): d.slot = SLOT_W'(SLOT_GATE);
            WIDX_W'(3): d.slot = SLOT_W'(SLOT_DISP);
            WIDX_W'(4): d.slot = SLOT_W'(SLOT_PIX);
            WIDX_W'(5): d.slot = SLOT_W'(SLOT_CACHE);
            WIDX_W'(7): d.slot = SLOT_W'(SLOT_CAM);
            default:    d.hit  = 1'b0;
        endcase
        return d;
    endfunction

    function automatic logic [DW-1:0] slot_reset(input int s);
        return (s == SLOT_GATE) ? {DW{1'b1}} : {DW{1'b0}};
    endfunction

    // Bit group owned by each subsystem in the reset and gate words.
    function automatic logic [DW-1:0] sub_group(input int k);
        case (k)
            0:       return 32'h0000_000C;
            1:       return 32'h0000_0070;
            2:       return 32'h0000_0180;
            3:       return 32'h0000_0600;
            default: return 32'h0000_1800;
        endcase
    endfunction

    function automatic int chan_slot(input int c);
        case (c)
            0:       return SLOT_DISP;
            1, 2:    return SLOT_PIX;
            default: return SLOT_CAM;
        endcase
    endfunction

    // Lowest bit of the configured nibble; fallback nibble sits just above.
    function automatic int chan_lsb(input int c);
        case (c)
            0:       return 8;
            1:       return 24;
            2:       return 16;
            default: return (c - 3) * 8;
        endcase
    endfunction

endpackage

// File: rtl/media_ctl_decode.sv
module media_ctl_decode
    import media_ctl_pkg::*;
(
    input  logic [AW-1:0] addr,
    output decode_t       dec
);
    decode_t word_d;

    always_comb begin
        word_d = word_decode(addr[AW-1:2]);
        dec    = word_d;
        if (addr[1:0] != 2'b00) begin
            dec.hit = 1'b0;
        end
    end

endmodule

// File: rtl/media_ctl_regbank.sv
module media_ctl_regbank
    import media_ctl_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  bus_req_t                    req,
    input  decode_t                     dec,
    output bus_rsp_t                    rsp,
    output logic [NSLOT-1:0][DW-1:0]    regs
);
    logic [NSLOT-1:0][DW-1:0] regs_q;
    bus_rsp_t                 rsp_q;
    logic                     wr_hit;
    logic [DW-1:0]            rd_word;

    assign wr_hit  = req.sel && req.wr && dec.hit;
    assign rd_word = regs_q[dec.slot];

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        localparam logic [DW-1:0] RVAL = slot_reset(s);
        always_ff @(posedge clk) begin
            if (rst) begin
                regs_q[s] <= RVAL;
            end else if (wr_hit && (dec.slot == SLOT_W'(s))) begin
                regs_q[s] <= req.wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q <= '0;
        end else begin
            rsp_q.ready <= req.sel;
            rsp_q.err   <= req.sel && !dec.hit;
            rsp_q.rdata <= (req.sel && !req.wr && dec.hit) ? rd_word : '0;
        end
    end

    assign rsp  = rsp_q;
    assign regs = regs_q;

    AST_REFUSED_KEEPS_STATE: assert property (@(posedge clk) disable iff (rst)
        (req.sel && !dec.hit) |=> $stable(regs_q)); // R3

    AST_READ_KEEPS_STATE: assert property (@(posedge clk) disable iff (rst)
        (req.sel && !req.wr) |=> $stable(regs_q)); // R2

endmodule

// File: rtl/media_ctl_fields.sv
module media_ctl_fields
    import media_ctl_pkg::*;
(
    input  logic [NSLOT-1:0][DW-1:0] regs,
    output logic [NSUB-1:0]          sub_rst_n,
    output logic [NSUB-1:0]          sub_clk_gate,
    output logic [NCH*PW-1:0]        prio_cfg,
    output logic [NCH*PW-1:0]        prio_dflt
);
    logic [DW-1:0] rst_word;
    logic [DW-1:0] gate_word;

    assign rst_word  = regs[SLOT_RST];
    assign gate_word = regs[SLOT_GATE];

    for (genvar k = 0; k < NSUB; k++) begin : g_sub
        localparam logic [DW-1:0] GRP = sub_group(k);
        assign sub_rst_n[k]    = &(rst_word | ~GRP);
        assign sub_clk_gate[k] = |(gate_word & GRP);
    end

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        localparam int SL = chan_slot(c);
        localparam int LB = chan_lsb(c);
        assign prio_cfg[c*PW +: PW]  = regs[SL][LB +: PW];
        assign prio_dflt[c*PW +: PW] = regs[SL][LB+PW +: PW];
    end

endmodule

// File: rtl/media_ctl_regs.sv
module media_ctl_regs
    import media_ctl_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [11:0]          bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    output logic                 bus_ready,
    output logic                 bus_err,
    output logic [4:0]           sub_rst_n,
    output logic [4:0]           sub_clk_gate,
    output logic [27:0]          prio_cfg,
    output logic [27:0]          prio_dflt
);
    bus_req_t                 req;
    bus_rsp_t                 rsp;
    decode_t                  dec;
    logic [NSLOT-1:0][DW-1:0] regs;

    assign req.sel   = bus_sel;
    assign req.wr    = bus_wr;
    assign req.addr  = bus_addr;
    assign req.wdata = bus_wdata;

    media_ctl_decode u_decode (
        .addr (req.addr),
        .dec  (dec)
    );

    media_ctl_regbank u_bank (
        .clk  (clk),
        .rst  (rst),
        .req  (req),
        .dec  (dec),
        .rsp  (rsp),
        .regs (regs)
    );

    media_ctl_fields u_fields (
        .regs         (regs),
        .sub_rst_n    (sub_rst_n),
        .sub_clk_gate (sub_clk_gate),
        .prio_cfg     (prio_cfg),
        .prio_dflt    (prio_dflt)
    );

    assign bus_rdata = rsp.rdata;
    assign bus_ready = rsp.ready;
    assign bus_err   = rsp.err;

    AST_READY_FOLLOWS_SEL: assert property (@(posedge clk) disable iff (rst)
        bus_sel |=> bus_ready); // R4

    AST_NO_SPURIOUS_READY: assert property (@(posedge clk) disable iff (rst)
        !bus_sel |=> !bus_ready); // R4

    AST_ERR_WITH_READY: assert property (@(posedge clk) disable iff (rst)
        bus_err |-> bus_ready); // R4

    AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (rst)
        bus_err |-> (bus_rdata == '0)); // R3

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (sub_rst_n == '0 && sub_clk_gate == '1)); // R1

endmodule

// File: tb/test_media_ctl_regs.sv
module test_media_ctl_regs;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_ready;
    logic        bus_err;
    logic [4:0]  sub_rst_n;
    logic [4:0]  sub_clk_gate;
    logic [27:0] prio_cfg;
    logic [27:0] prio_dflt;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    logic [32:0] exp_q[$];
    string       tag_q[$];
    logic [31:0] model [6];

    always #(CLK_PERIOD/2) clk = ~clk;

    media_ctl_regs i_media_ctl_regs (
        .clk, .rst, .bus_sel, .bus_wr, .bus_addr, .bus_wdata,
        .bus_rdata, .bus_ready, .bus_err,
        .sub_rst_n, .sub_clk_gate, .prio_cfg, .prio_dflt
    );

    task automatic check_val(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Address map from R2: returns slot index or -1.
    function automatic int slot_of(input logic [11:0] a);
        if (a[1:0] != 2'b00) return -1;
        case (a)
            12'h000: return 0;
            12'h004: return 1;
            12'h00C: return 2;
            12'h010: return 3;
            12'h014: return 4;
            12'h01C: return 5;
            default: return -1;
        endcase
    endfunction

    // Groups from R5/R6.
    function automatic logic [31:0] grp(input int k);
        case (k)
            0: return 32'h0000_000C;
            1: return 32'h0000_0070;
            2: return 32'h0000_0180;
            3: return 32'h0000_0600;
            default: return 32'h0000_1800;
        endcase
    endfunction

    // Field positions from R7, R8, R9: {word, configured lsb}.
    function automatic logic [3:0] prio_field(input int c, input bit dflt);
        logic [31:0] w;
        int lsb;
        case (c)
            0: begin w = model[2]; lsb = 8;  end
            1: begin w = model[3]; lsb = 24; end
            2: begin w = model[3]; lsb = 16; end
            default: begin w = model[5]; lsb = (c - 3) * 8; end
        endcase
        if (dflt) lsb = lsb + 4;
        return w[lsb +: 4];
    endfunction

    task automatic check_outputs(input string tag);
        logic [4:0]  e_rst;
        logic [4:0]  e_gate;
        logic [27:0] e_cfg;
        logic [27:0] e_dfl;
        for (int k = 0; k < 5; k++) begin
            e_rst[k]  = ((model[0] & grp(k)) == grp(k));
            e_gate[k] = ((model[1] & grp(k)) != 0);
        end
        for (int c = 0; c < 7; c++) begin
            e_cfg[c*4 +: 4] = prio_field(c, 1'b0);
            e_dfl[c*4 +: 4] = prio_field(c, 1'b1);
        end
        check_val({tag, " R5 sub_rst_n"}, {27'd0, sub_rst_n}, {27'd0, e_rst});
        check_val({tag, " R6 sub_clk_gate"}, {27'd0, sub_clk_gate}, {27'd0, e_gate});
        check_val({tag, " R11 prio_cfg"}, {4'd0, prio_cfg}, {4'd0, e_cfg});
        check_val({tag, " R11 prio_dflt"}, {4'd0, prio_dflt}, {4'd0, e_dfl});
    endtask

    // Driver: predicts the response, pushes it, then drives one strobe.
    task automatic bus(input logic wr, input logic [11:0] a, input logic [31:0] d, input string tag);
        int s;
        logic [31:0] e_rd;
        s = slot_of(a);
        e_rd = (s >= 0 && !wr) ? model[s] : 32'h0;
        exp_q.push_back({(s < 0), e_rd});
        tag_q.push_back(tag);
        if (wr && s >= 0) model[s] = d;
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
        @(negedge clk);
        check_val({tag, " R4 ready drops"}, {31'd0, bus_ready}, 32'd0);
    endtask

    // Monitor: pops predicted responses as ready pulses appear.
    always @(negedge clk) begin
        if (!rst && bus_ready) begin
            if (exp_q.size() == 0) begin
                check_val("R4 unexpected ready", 32'd1, 32'd0);
            end else begin
                logic [32:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check_val({t, " rdata"}, bus_rdata, e[31:0]);
                check_val({t, " err"}, {31'd0, bus_err}, {31'd0, e[32]});
            end
        end
    end

    task automatic read_all(input string tag);
        bus(1'b0, 12'h000, '0, tag);
        bus(1'b0, 12'h004, '0, tag);
        bus(1'b0, 12'h00C, '0, tag);
        bus(1'b0, 12'h010, '0, tag);
        bus(1'b0, 12'h014, '0, tag);
        bus(1'b0, 12'h01C, '0, tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        model[0] = 32'h0; model[1] = 32'hFFFF_FFFF; model[2] = 32'h0;
        model[3] = 32'h0; model[4] = 32'h0; model[5] = 32'h0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check_val("R1 ready idle", {31'd0, bus_ready}, 32'd0);
        check_outputs("R1 reset");
        read_all("R1 reset readback");

        // R5 reset release: full, partial groups
        bus(1'b1, 12'h000, 32'h0000_1800, "R5 write one group");
        check_outputs("R5 one group");
        bus(1'b1, 12'h000, 32'h0000_0FFC, "R5 write partial top");
        check_outputs("R5 partial");
        bus(1'b1, 12'h000, 32'h0000_1FCC, "R5 write display partial");
        check_outputs("R5 display partial");
        bus(1'b1, 12'h000, 32'hFFFF_FFFF, "R5 write all");
        check_outputs("R5 all");

        // R6 clock gating
        bus(1'b1, 12'h004, 32'h0000_0000, "R6 write none");
        check_outputs("R6 none");
        bus(1'b1, 12'h004, 32'h0000_0040, "R6 write display bit");
        check_outputs("R6 single");
        bus(1'b1, 12'h004, 32'hFFFF_E003, "R6 write outside groups");
        check_outputs("R6 outside");

        // R7, R8, R9 priority fields
        bus(1'b1, 12'h00C, 32'h0000_73A5, "R7 write display");
        check_outputs("R7 display");
        bus(1'b1, 12'h010, 32'h3624_8100, "R8 write pixel");
        check_outputs("R8 pixel");
        bus(1'b1, 12'h01C, 32'h7362_5140, "R9 write sensor");
        check_outputs("R9 sensor");
        bus(1'b1, 12'h01C, 32'hFEDC_BA98, "R9 write sensor high");
        check_outputs("R9 sensor high");

        // R10 cache word: no output moves
        bus(1'b1, 12'h014, 32'hDEAD_BEEF, "R10 write cache");
        check_outputs("R10 no output effect");

        // R2 readback of everything written
        read_all("R2 readback");

        // R3 refused accesses
        bus(1'b1, 12'h008, 32'h1234_5678, "R3 write 0x8");
        bus(1'b1, 12'h018, 32'h1234_5678, "R3 write 0x18");
        bus(1'b1, 12'h020, 32'h1234_5678, "R3 write 0x20");
        bus(1'b1, 12'hFFC, 32'h1234_5678, "R3 write 0xFFC");
        bus(1'b1, 12'h002, 32'h0000_0000, "R3 write misaligned");
        bus(1'b1, 12'h005, 32'h0000_0000, "R3 write misaligned gate");
        bus(1'b0, 12'h008, '0, "R3 read 0x8");
        bus(1'b0, 12'h011, '0, "R3 read misaligned");
        check_outputs("R3 outputs kept");
        read_all("R3 state kept");

        // R4 back-to-back style pattern with writes returning zero
        bus(1'b1, 12'h000, 32'h0000_0000, "R4 write returns zero");
        check_outputs("R4 after clear");

        repeat (3) @(negedge clk);
        check_val("R4 queue drained", exp_q.size(), 32'd0);
        finish_run();
    end

endmodule